// File: doc/BRIEF.md
# Dual-Issue In-Order Hazard Checker

This block sits between fetch/decode and the execution units of a two-way in-order pipeline. It holds a pair of decoded instructions, older and younger, and decides each cycle how many of them go out. Each instruction carries a valid bit, a destination register, two source registers and a unit class. The younger instruction may issue only alongside the older one. It must not read or write the older one's destination, and it must not need the same single-instance unit. When the pair splits, the younger instruction moves into the older slot and a bubble fills the issue slot it left.

The block also keeps one busy bit per register for results that take many cycles. An issued multiply sets the bit for its destination, and a writeback on the writeback port clears it. Any later instruction that reads or writes a busy register waits. The fetch stage sees `fetch_stall`. When it is low, both presented instructions are taken. When the pair splits, only the first presented instruction is taken. When the older instruction is blocked, neither is taken.

Top module: `pair_issue_gate`

## Requirements
- R1: While `rst` is high at a clock edge, both slots are emptied and every busy bit is cleared, so in the next cycle `issue_old`, `issue_young` and `fetch_stall` are all 0.
- R2: Unit classes are encoded 0 = integer (two units), 1 = multiply, 2 = floating point, 3 = load/store (one unit each). A valid older instruction with no busy register issues. A valid younger instruction with no conflict issues in the same cycle, and this includes two integer operations.
- R3: If the younger instruction reads (either source) the older instruction's destination, the younger is held: `issue_young` = 0 and `fetch_stall` = 1 while the older issues.
- R4: If the younger instruction writes the same destination as the older, it is held the same way.
- R5: If both instructions use the same class and that class is not integer, the younger is held.
- R6: After a split, the held younger instruction occupies the older slot in the next cycle and the first presented instruction (`in0_*`) enters the younger slot. The second presented instruction is not taken.
- R7: Issuing a multiply-class instruction marks its destination busy. An instruction whose source or destination is busy does not issue until a writeback for that register (`wb_valid`, `wb_reg`) has been clocked in.
- R8: While a valid older instruction is blocked, the younger never issues, the pair is held unchanged and `fetch_stall` = 1.
- R9: When every valid slot issues, or both slots are empty, `fetch_stall` = 0 and both presented instructions are loaded at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in0_valid | input | 1 | First presented instruction valid |
| in0_dst | input | RW | First presented destination register |
| in0_srca | input | RW | First presented source A |
| in0_srcb | input | RW | First presented source B |
| in0_unit | input | 2 | First presented unit class |
| in1_valid | input | 1 | Second presented instruction valid |
| in1_dst | input | RW | Second presented destination register |
| in1_srca | input | RW | Second presented source A |
| in1_srcb | input | RW | Second presented source B |
| in1_unit | input | 2 | Second presented unit class |
| wb_valid | input | 1 | Long-latency writeback strobe |
| wb_reg | input | RW | Register written back |
| issue_old | output | 1 | Older slot issues this cycle |
| issue_young | output | 1 | Younger slot issues this cycle |
| fetch_stall | output | 1 | Fetch must not advance by two |

RW = $clog2(NREG).

## Verification
The issue enables and the stall are combinational from the registered pair and busy bits. They are due in the cycle after the edge that loads a pair, a split shift, or a busy set or clear. The bench drives every input on the falling edge and samples one time unit later, so each check looks at exactly one edge's effect. A sweep over all register and class combinations in a four-register configuration checks the first cycle of each pair and the cycle after it. That second cycle covers the shifted instruction and the multiply busy bit. Directed sequences cover the blocked-older hold, the writeback release and the entry of `in0_*` into the younger slot.

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in0_valid,
  input  logic [RW-1:0] in0_dst,
  input  logic [RW-1:0] in0_srca,
  input  logic [RW-1:0] in0_srcb,
  input  logic [1:0]    in0_unit,
  input  logic          in1_valid,
  input  logic [RW-1:0] in1_dst,
  input  logic [RW-1:0] in1_srca,
  input  logic [RW-1:0] in1_srcb,
  input  logic [1:0]    in1_unit,
  input  logic          wb_valid,
  input  logic [RW-1:0] wb_reg,
  output logic          issue_old,
  output logic          issue_young,
  output logic          fetch_stall
);
  localparam logic [1:0] U_INT = 2'd0;
  localparam logic [1:0] U_MUL = 2'd1;

  logic          o_v, y_v;
  logic [RW-1:0] o_d, o_a, o_b, y_d, y_a, y_b;
  logic [1:0]    o_c, y_c;
  logic [NREG-1:0] busy, busy_n;

  wire o_blk = busy[o_a] | busy[o_b] | busy[o_d];
  wire y_blk = busy[y_a] | busy[y_b] | busy[y_d];
  wire raw   = (y_a == o_d) | (y_b == o_d);
  wire waw   = (y_d == o_d);
  wire strc  = (y_c == o_c) & (o_c != U_INT);
  wire pair_cf = o_v & (raw | waw | strc);

  assign issue_old   = o_v & ~o_blk;
  wire   o_done      = ~o_v | issue_old;
  assign issue_young = y_v & o_done & ~pair_cf & ~y_blk;
  wire   y_done      = ~y_v | issue_young;
  assign fetch_stall = ~(o_done & y_done);

  always_comb begin
    busy_n = busy;
    if (wb_valid) busy_n[wb_reg] = 1'b0;
    if (issue_old && o_c == U_MUL) busy_n[o_d] = 1'b1;
    if (issue_young && y_c == U_MUL) busy_n[y_d] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
      o_v  <= 1'b0;
      y_v  <= 1'b0;
      o_d <= '0; o_a <= '0; o_b <= '0; o_c <= U_INT;
      y_d <= '0; y_a <= '0; y_b <= '0; y_c <= U_INT;
    end else begin
      busy <= busy_n;
      if (o_done && y_done) begin
        o_v <= in0_valid; o_d <= in0_dst; o_a <= in0_srca; o_b <= in0_srcb; o_c <= in0_unit;
        y_v <= in1_valid; y_d <= in1_dst; y_a <= in1_srca; y_b <= in1_srcb; y_c <= in1_unit;
      end else if (o_done) begin
        o_v <= y_v; o_d <= y_d; o_a <= y_a; o_b <= y_b; o_c <= y_c;
        y_v <= in0_valid; y_d <= in0_dst; y_a <= in0_srca; y_b <= in0_srcb; y_c <= in0_unit;
      end
    end
  end
endmodule

module pair_issue_chk #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_old,
  input logic            issue_young,
  input logic            fetch_stall,
  input logic            o_v,
  input logic            y_v,
  input logic [RW-1:0]   o_d,
  input logic [RW-1:0]   o_a,
  input logic [RW-1:0]   o_b,
  input logic [1:0]      o_c,
  input logic [RW-1:0]   y_d,
  input logic [RW-1:0]   y_a,
  input logic [RW-1:0]   y_b,
  input logic [NREG-1:0] busy
);
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (!issue_old && !issue_young && !fetch_stall));

  // R3
  raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (o_v && y_v && (y_a == o_d || y_b == o_d)) |-> !issue_young);

  // R6
  split_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_old && y_v && !issue_young) |=>
      (o_v && o_d == $past(y_d) && o_a == $past(y_a) && o_b == $past(y_b)));

  // R7
  mul_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_old && o_c == 2'd1) |=> busy[$past(o_d)]);

  // R8
  order_chk: assert property (@(posedge clk) disable iff (rst)
    issue_young |-> (issue_old || !o_v));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (o_v && !issue_old) |=> (o_v && $stable(o_d) && $stable(o_a) && $stable(o_b)));
endmodule

bind pair_issue_gate pair_issue_chk #(.NREG(NREG), .RW(RW)) u_chk (.*);

// File: tb/test_pair_issue_gate.sv
`timescale 1ns/1ps
module test_pair_issue_gate;
  localparam int NREG = 4;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in0_valid, in1_valid, wb_valid;
  logic [RW-1:0] in0_dst, in0_srca, in0_srcb, in1_dst, in1_srca, in1_srcb, wb_reg;
  logic [1:0] in0_unit, in1_unit;
  logic issue_old, issue_young, fetch_stall;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pair_issue_gate #(.NREG(NREG)) i_pair_issue_gate (
    .clk(clk), .rst(rst),
    .in0_valid(in0_valid), .in0_dst(in0_dst), .in0_srca(in0_srca), .in0_srcb(in0_srcb), .in0_unit(in0_unit),
    .in1_valid(in1_valid), .in1_dst(in1_dst), .in1_srca(in1_srca), .in1_srcb(in1_srcb), .in1_unit(in1_unit),
    .wb_valid(wb_valid), .wb_reg(wb_reg),
    .issue_old(issue_old), .issue_young(issue_young), .fetch_stall(fetch_stall));

  task automatic set0(input logic v, input int d, input int a, input int b, input int c);
    in0_valid = v; in0_dst = RW'(d); in0_srca = RW'(a); in0_srcb = RW'(b); in0_unit = 2'(c);
  endtask
  task automatic set1(input logic v, input int d, input int a, input int b, input int c);
    in1_valid = v; in1_dst = RW'(d); in1_srca = RW'(a); in1_srcb = RW'(b); in1_unit = 2'(c);
  endtask
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic chk(input string req, input logic [2:0] exp);
    #1;
    checks++;
    if ({issue_old, issue_young, fetch_stall} !== exp) begin
      errors++;
      $display("FAIL %s: {old,young,stall} actual %b expected %b", req,
               {issue_old, issue_young, fetch_stall}, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wb_valid = 0; wb_reg = '0;
    set0(1, 1, 2, 3, 0); set1(1, 2, 3, 0, 0);
    @(negedge clk);
    step();
    chk("R1 reset state", 3'b000);

    // R7 R8: blocked older holds pair, younger never issues
    rst = 0;
    set0(1, 1, 2, 3, 1); set1(0, 0, 0, 0, 0);
    step(); chk("R2 lone multiply", 3'b100);
    set0(1, 2, 1, 0, 0); set1(1, 3, 0, 0, 0);
    step(); chk("R7 busy source blocks older", 3'b001);
    set0(0, 0, 0, 0, 0); set1(0, 0, 0, 0, 0);
    step(); chk("R8 pair held while blocked", 3'b001);
    wb_valid = 1; wb_reg = 2'd1;
    step(); wb_valid = 0;
    chk("R7 writeback releases", 3'b110);
    step(); chk("R9 empty pair after drain", 3'b000);

    // R6: in0 enters younger slot after split
    set0(1, 1, 2, 2, 0); set1(1, 2, 1, 0, 0);
    step(); chk("R3 raw split", 3'b101);
    set0(1, 0, 2, 3, 0); set1(1, 3, 0, 0, 0);
    step(); chk("R6 in0 into younger slot conflicts", 3'b101);
    set0(1, 3, 0, 0, 0); set1(0, 0, 0, 0, 0);
    step(); chk("R6 second shift", 3'b101);
    set0(0, 0, 0, 0, 0);
    step(); chk("R6 last instruction alone", 3'b100);

    // sweep
    for (int dO = 0; dO < 4; dO++)
      for (int cO = 0; cO < 4; cO++)
        for (int cY = 0; cY < 4; cY++)
          for (int yd = 0; yd < 4; yd++)
            for (int ya = 0; ya < 4; ya++)
              for (int yb = 0; yb < 4; yb++) begin
                logic raw, waw, st, split, blk;
                raw = (ya == dO) || (yb == dO);
                waw = (yd == dO);
                st = (cO == cY) && (cO != 0);
                split = raw || waw || st;
                blk = (cO == 1) && (raw || waw);
                rst = 1; set0(0, 0, 0, 0, 0); set1(0, 0, 0, 0, 0);
                step(); rst = 0;
                set0(1, dO, (dO + 1) % 4, (dO + 1) % 4, cO); set1(1, yd, ya, yb, cY);
                step();
                set0(0, 0, 0, 0, 0); set1(0, 0, 0, 0, 0);
                if (!split) chk("R2 independent pair", 3'b110);
                else if (raw) chk("R3 raw held", 3'b101);
                else if (waw) chk("R4 waw held", 3'b101);
                else chk("R5 structural held", 3'b101);
                step();
                if (!split) chk("R9 drained", 3'b000);
                else if (blk) chk("R7 shifted waits on busy", 3'b001);
                else chk("R6 shifted issues", 3'b100);
                if (split && blk) begin
                  wb_valid = 1; wb_reg = RW'(dO);
                  step(); wb_valid = 0;
                  chk("R7 released by writeback", 3'b100);
                end
              end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule